// File: doc/BRIEF.md
# Half-Word Splitting Bus Bridge with Byte-Order Conversion

This block sits between a 32-bit system port and a 16-bit peripheral bus. A system request (address, write data, byte enables, a direction, a byte-order mode and a size) is taken through a valid/ready handshake. A 32-bit request is then run as two peripheral cycles with no idle clock between them. A 16-bit request runs as a single peripheral cycle. Each peripheral cycle raises a strobe and waits for an acknowledge. The cycle also honours a programmable minimum length of at least four clocks.

The selected byte-order conversion is applied to write data and byte enables before they are split into half-words. For reads, it is applied to the reassembled word before it is returned. Completion of every request, read or write, is signalled by one response-valid pulse. Only one request is in flight at a time.

Top module: `bus_width_splitter`

## Requirements
- R1: After reset `req_ready` is 1, `nb_stb` is 0 and `rsp_valid` is 0.
- R2: A request with `req_size`=1 runs exactly two peripheral cycles. The first is at address A and carries the low half-word. The second is at A+2 and carries the high half-word. `nb_stb` stays high from the first cycle into the second, so the second cycle starts on the clock after the first one ends.
- R3: Every peripheral cycle keeps `nb_stb` high for at least max(`cyc_len_min`, 4) clocks. Any `cyc_len_min` setting below 4 acts as 4.
- R4: A cycle ends at whichever comes later: the clock in which `nb_ack` is sampled high, or the end of the minimum length. If the acknowledge is sampled in strobe clock number d+1 of the cycle, the cycle lasts max(minimum, d+1) clocks.
- R5: `req_swap` selects the byte order for 32-bit requests. 00 passes bytes unchanged. 01 swaps the two bytes inside each half-word. 10 reverses all four bytes (byte 0 becomes byte 3). 11 passes bytes unchanged. The same lane permutation is applied to `req_be`.
- R6: A read returns {second half-word, first half-word}, converted by the selected byte order, on `rsp_rdata`. It is returned with a single one-clock `rsp_valid` pulse after the last peripheral cycle.
- R7: A request with `req_size`=0 runs one peripheral cycle at A, using `req_wdata[15:0]` and `req_be[1:0]`. Modes 01 and 10 both swap the two bytes, and 00 and 11 pass them unchanged. A read returns the converted half-word in `rsp_rdata[15:0]` with `rsp_rdata[31:16]`=0.
- R8: `req_ready` is low from the clock after acceptance until the response pulse has been given. No request is accepted in that window. Writes also end with one `rsp_valid` pulse.
- R9: `nb_we` equals the accepted request's `req_write`, and `nb_addr` changes only from A to A+2 while `nb_stb` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_len_min | input | LEN_W | Minimum strobe clocks per peripheral cycle (floor of 4) |
| req_valid | input | 1 | System request valid |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_addr | input | ADDR_W | Request byte address A |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_swap | input | 2 | Byte-order mode |
| req_size | input | 1 | 1 = 32-bit, 0 = 16-bit |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read result, valid with `rsp_valid` on reads |
| nb_stb | output | 1 | Peripheral cycle strobe |
| nb_we | output | 1 | Peripheral write direction |
| nb_addr | output | ADDR_W | Peripheral byte address |
| nb_wdata | output | 16 | Peripheral write half-word |
| nb_be | output | 2 | Peripheral byte enables |
| nb_ack | input | 1 | Peripheral acknowledge, sampled while `nb_stb` is high |
| nb_rdata | input | 16 | Peripheral read half-word, valid with `nb_ack` |

## Verification
A wrong phase bit or sequencer state shows up at once at the peripheral port. The symptom is a missing or third cycle, a wrong address step, or a strobe gap, and it appears on the clock the first cycle ends. A faulty cycle timer makes a strobe window too short or too long. This is visible at the segment boundary, within a few clocks of the acknowledge. A bad byte-lane permutation or capture register only appears in the written half-words or in the single response word, so every mode is driven with distinct byte patterns for both directions.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int SYS_LANES = 4;
  localparam int NB_LANES  = 2;
  localparam int LANE_W    = 8;
  localparam int SYS_DW    = SYS_LANES * LANE_W;
  localparam int NB_DW     = NB_LANES * LANE_W;

  localparam logic [1:0] SWAP_PASS  = 2'b00;
  localparam logic [1:0] SWAP_HALF  = 2'b01;
  localparam logic [1:0] SWAP_WORD  = 2'b10;
  localparam logic [1:0] SWAP_PASS2 = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUS  = 2'b01,
    ST_RESP = 2'b10
  } seq_state_e;
endpackage

// File: rtl/hws_lane_swap.sv
module hws_lane_swap #(
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic [1:0]          mode,
  input  logic                wide,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout
);
  localparam int NARROW = LANES / 2;

  logic sel_half;
  logic sel_word;

  always_comb begin
    sel_word = (mode == hws_pkg::SWAP_WORD) && wide;
    sel_half = (mode == hws_pkg::SWAP_HALF) ||
               ((mode == hws_pkg::SWAP_WORD) && !wide);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HALF_SRC = i ^ 1;
    localparam int WORD_SRC = LANES - 1 - i;
    if (i < NARROW) begin : g_low
      assign dout[i*LW +: LW] = sel_word ? din[WORD_SRC*LW +: LW] :
                                sel_half ? din[HALF_SRC*LW +: LW] :
                                           din[i*LW +: LW];
    end else begin : g_high
      logic half_here;
      assign half_here = sel_half && wide;
      assign dout[i*LW +: LW] = sel_word  ? din[WORD_SRC*LW +: LW] :
                                half_here ? din[HALF_SRC*LW +: LW] :
                                            din[i*LW +: LW];
    end
  end
endmodule

// File: rtl/hws_cycle_timer.sv
module hws_cycle_timer #(
  parameter int LEN_W = 4,
  parameter int FLOOR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             ack,
  input  logic [LEN_W-1:0] min_len,
  output logic             done
);
  localparam logic [LEN_W-1:0] FLOOR_V = LEN_W'(FLOOR);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             acked_q, acked_d;
  logic [LEN_W-1:0] eff_min;
  logic             min_met;

  always_comb begin
    eff_min = (min_len < FLOOR_V) ? FLOOR_V : min_len;
    min_met = cnt_q >= (eff_min - LEN_W'(1));
    done    = active && (ack || acked_q) && min_met;
  end

  always_comb begin
    cnt_d   = cnt_q;
    acked_d = acked_q;
    if (!active || done) begin
      cnt_d   = '0;
      acked_d = 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + LEN_W'(1);
      if (ack) acked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acked_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      acked_q <= acked_d;
    end
  end
endmodule

// File: rtl/hws_sequencer.sv
module hws_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic wide,
  input  logic cyc_done,
  output logic req_ready,
  output logic accept,
  output logic bus_active,
  output logic phase_hi,
  output logic rsp_valid
);
  import hws_pkg::*;

  seq_state_e state_q, state_d;
  logic       phase_q, phase_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_BUS;
          phase_d = 1'b0;
        end
      end
      ST_BUS: begin
        if (cyc_done) begin
          if (wide && !phase_q) phase_d = 1'b1;
          else                  state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign bus_active = (state_q == ST_BUS);
  assign rsp_valid  = (state_q == ST_RESP);
  assign phase_hi   = phase_q;
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 4,
  parameter int MIN_FLOOR = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LEN_W-1:0]          cyc_len_min,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [hws_pkg::SYS_DW-1:0] req_wdata,
  input  logic [hws_pkg::SYS_LANES-1:0] req_be,
  input  logic                      req_write,
  input  logic [1:0]                req_swap,
  input  logic                      req_size,
  output logic                      rsp_valid,
  output logic [hws_pkg::SYS_DW-1:0] rsp_rdata,
  output logic                      nb_stb,
  output logic                      nb_we,
  output logic [ADDR_W-1:0]         nb_addr,
  output logic [hws_pkg::NB_DW-1:0] nb_wdata,
  output logic [hws_pkg::NB_LANES-1:0] nb_be,
  input  logic                      nb_ack,
  input  logic [hws_pkg::NB_DW-1:0] nb_rdata
);
  import hws_pkg::*;

  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(NB_LANES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic accept, bus_active, phase_hi, cyc_done;
  logic [SYS_DW-1:0]    wdata_sw;
  logic [SYS_LANES-1:0] be_sw;

  logic [ADDR_W-1:0]    addr_q;
  logic                 we_q, wide_q;
  logic [1:0]           swap_q;
  logic [SYS_DW-1:0]    wdata_q;
  logic [SYS_LANES-1:0] be_q;
  logic [NB_DW-1:0]     lo_q, hi_q;
  logic [SYS_DW-1:0]    rd_raw;

  hws_lane_swap #(.LANES(SYS_LANES), .LW(LANE_W)) u_wswap (
    .mode (req_swap),
    .wide (req_size),
    .din  (req_wdata),
    .dout (wdata_sw)
  );

  hws_lane_swap #(.LANES(SYS_LANES), .LW(1)) u_beswap (
    .mode (req_swap),
    .wide (req_size),
    .din  (req_be),
    .dout (be_sw)
  );

  hws_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .req_valid  (req_valid),
    .wide       (wide_q),
    .cyc_done   (cyc_done),
    .req_ready  (req_ready),
    .accept     (accept),
    .bus_active (bus_active),
    .phase_hi   (phase_hi),
    .rsp_valid  (rsp_valid)
  );

  hws_cycle_timer #(.LEN_W(LEN_W), .FLOOR(MIN_FLOOR)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .active  (bus_active),
    .ack     (nb_ack),
    .min_len (cyc_len_min),
    .done    (cyc_done)
  );

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      we_q    <= req_write;
      wide_q  <= req_size;
      swap_q  <= req_swap;
      wdata_q <= wdata_sw;
      be_q    <= be_sw;
    end
  end

  // read half-word capture, clock-enabled by a sampled acknowledge
  always_ff @(posedge clk) begin
    if (bus_active && nb_ack && !phase_hi) lo_q <= nb_rdata;
    if (bus_active && nb_ack &&  phase_hi) hi_q <= nb_rdata;
  end

  assign rd_raw = {(wide_q ? hi_q : {NB_DW{1'b0}}), lo_q};

  hws_lane_swap #(.LANES(SYS_LANES), .LW(LANE_W)) u_rswap (
    .mode (swap_q),
    .wide (wide_q),
    .din  (rd_raw),
    .dout (rsp_rdata)
  );

  assign nb_stb   = bus_active;
  assign nb_we    = we_q;
  assign nb_addr  = phase_hi ? (addr_q + HALF_STEP) : addr_q;
  assign nb_wdata = phase_hi ? wdata_q[SYS_DW-1:NB_DW] : wdata_q[NB_DW-1:0];
  assign nb_be    = phase_hi ? be_q[SYS_LANES-1:NB_LANES] : be_q[NB_LANES-1:0];
endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int FLOOR  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              nb_stb,
  input logic [ADDR_W-1:0] nb_addr,
  input logic [LEN_W-1:0]  cyc_len_min
);
  localparam logic [LEN_W:0] FLOOR_V = (LEN_W+1)'(FLOOR);

  logic              stb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W:0]    seg_cnt_q;
  logic [LEN_W:0]    want;
  logic              seg_end;

  assign want    = ({1'b0, cyc_len_min} < FLOOR_V) ? FLOOR_V : {1'b0, cyc_len_min};
  assign seg_end = stb_q && (!nb_stb || nb_addr != addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      addr_q    <= '0;
      seg_cnt_q <= '0;
    end else begin
      stb_q  <= nb_stb;
      addr_q <= nb_addr;
      if (nb_stb && (!stb_q || nb_addr != addr_q)) seg_cnt_q <= (LEN_W+1)'(1);
      else if (nb_stb && seg_cnt_q != {(LEN_W+1){1'b1}}) seg_cnt_q <= seg_cnt_q + 1'b1;
      else if (!nb_stb) seg_cnt_q <= '0;
      if (seg_end) begin
        p_min_len_r3: assert (seg_cnt_q >= want)
          else $error("strobe window shorter than minimum");
      end
    end
  end

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_stb || rsp_valid) |-> !req_ready);

  p_accept_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> nb_stb);

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_stb && $past(nb_stb) && nb_addr != $past(nb_addr))
      |-> (nb_addr == $past(nb_addr) + ADDR_W'(2)));
endmodule

bind bus_width_splitter hws_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .FLOOR  (MIN_FLOOR)
) u_hws_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .nb_stb      (nb_stb),
  .nb_addr     (nb_addr),
  .cyc_len_min (cyc_len_min)
);

// File: tb/tb_bus_width_splitter.sv
module tb_bus_width_splitter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cyc_len_min = 4'd4;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_swap = '0;
  logic        req_size = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        nb_stb, nb_we;
  logic [31:0] nb_addr;
  logic [15:0] nb_wdata;
  logic [1:0]  nb_be;
  logic        nb_ack = 1'b0;
  logic [15:0] nb_rdata = '0;

  int checks = 0;
  int fails  = 0;

  bus_width_splitter dut (
    .clk(clk), .rst_n(rst_n), .cyc_len_min(cyc_len_min),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
    .req_swap(req_swap), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nb_stb(nb_stb), .nb_we(nb_we), .nb_addr(nb_addr),
    .nb_wdata(nb_wdata), .nb_be(nb_be), .nb_ack(nb_ack), .nb_rdata(nb_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- peripheral model and segment log ----------------
  int          ack_dly = 0;
  int          seg_n;
  logic [31:0] seg_addr [4];
  logic [15:0] seg_wdata[4];
  logic [1:0]  seg_be   [4];
  logic        seg_we   [4];
  logic        seg_gap  [4];
  int          seg_len  [4];

  function automatic logic [15:0] rd_model(input logic [31:0] a);
    return {a[7:0] + 8'h11, a[7:0] + 8'h5A};
  endfunction

  initial begin
    bit          open = 0;
    bit          acked = 0;
    bit          prev_stb = 0;
    int          cnt = 0;
    logic [31:0] cur = '0;
    forever begin
      @(negedge clk);
      if (open && (!nb_stb || nb_addr != cur)) begin
        if (seg_n < 4) seg_len[seg_n] = cnt;
        seg_n = seg_n + 1;
        open = 0;
      end
      if (nb_stb && !open) begin
        open = 1; cur = nb_addr; cnt = 0; acked = 0;
        if (seg_n < 4) begin
          seg_addr[seg_n]  = nb_addr;
          seg_wdata[seg_n] = nb_wdata;
          seg_be[seg_n]    = nb_be;
          seg_we[seg_n]    = nb_we;
          seg_gap[seg_n]   = !prev_stb;
        end
      end
      nb_ack = 1'b0;
      if (open) begin
        cnt = cnt + 1;
        if (!acked && cnt == ack_dly + 1) begin
          nb_ack = 1'b1;
          nb_rdata = rd_model(cur);
          acked = 1;
        end
      end
      prev_stb = nb_stb;
    end
  end

  // ---------------- reference byte orders ----------------
  function automatic logic [31:0] ref_data(input logic [1:0] m, input logic w,
                                           input logic [31:0] x);
    logic [7:0] b [4];
    logic [7:0] o [4];
    for (int i = 0; i < 4; i++) b[i] = x[8*i +: 8];
    for (int i = 0; i < 4; i++) o[i] = b[i];
    if (w) begin
      if (m == 2'b01) begin o[0]=b[1]; o[1]=b[0]; o[2]=b[3]; o[3]=b[2]; end
      if (m == 2'b10) begin o[0]=b[3]; o[1]=b[2]; o[2]=b[1]; o[3]=b[0]; end
    end else if (m == 2'b01 || m == 2'b10) begin
      o[0] = b[1]; o[1] = b[0];
    end
    return {o[3], o[2], o[1], o[0]};
  endfunction

  function automatic logic [3:0] ref_be(input logic [1:0] m, input logic w,
                                        input logic [3:0] e);
    logic [31:0] spread;
    logic [31:0] moved;
    for (int i = 0; i < 4; i++) spread[8*i +: 8] = {8{e[i]}};
    moved = ref_data(m, w, spread);
    return {moved[24], moved[16], moved[8], moved[0]};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- one full request with checks ----------------
  task automatic run_req(input logic [31:0] a, input logic [31:0] wd,
                         input logic [3:0] be, input logic we,
                         input logic [1:0] m, input logic w,
                         input int dly, input logic [3:0] mn,
                         input bit hold, input string tag);
    int  got = 0;
    bit  busy_ok = 1;
    int  exp_len;
    int  exp_n;
    logic [31:0] rdat = '0;
    logic [31:0] wexp;
    logic [3:0]  bexp;
    logic [31:0] rexp;
    exp_len = (mn < 4) ? 4 : int'(mn);
    if (dly + 1 > exp_len) exp_len = dly + 1;
    exp_n = w ? 2 : 1;
    @(negedge clk);
    ack_dly = dly; cyc_len_min = mn;
    req_addr = a; req_wdata = wd; req_be = be; req_write = we;
    req_swap = m; req_size = w; req_valid = 1'b1;
    seg_n = 0;
    check(req_ready === 1'b1, {tag, " R8 ready before request"}, 32'(req_ready), 1);
    @(negedge clk);
    if (hold) begin
      req_addr = a + 32'h100; req_wdata = ~wd; req_swap = ~m;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < 300; k++) begin
      if (rsp_valid === 1'b1) begin
        got = 1; rdat = rsp_rdata; break;
      end
      if (req_ready !== 1'b0) busy_ok = 0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(busy_ok, {tag, " R8 ready low while busy"}, 32'(busy_ok), 1);
    check(got == 1, {tag, " R8 response pulse"}, 32'(got), 1);
    @(negedge clk);
    check(rsp_valid === 1'b0, {tag, " R6 single response pulse"}, 32'(rsp_valid), 0);
    check(seg_n == exp_n, {tag, " R2 R7 cycle count"}, 32'(seg_n), 32'(exp_n));
    wexp = ref_data(m, w, wd);
    bexp = ref_be(m, w, be);
    for (int s = 0; s < exp_n && s < seg_n; s++) begin
      check(seg_addr[s] == a + 32'(2*s), {tag, " R2 cycle address"}, seg_addr[s], a + 32'(2*s));
      check(seg_len[s] == exp_len, {tag, " R3 R4 strobe length"}, 32'(seg_len[s]), 32'(exp_len));
      check(seg_we[s] == we, {tag, " R9 direction"}, 32'(seg_we[s]), 32'(we));
      if (we) begin
        check(seg_wdata[s] == wexp[16*s +: 16], {tag, " R5 R7 write half-word"},
              32'(seg_wdata[s]), 32'(wexp[16*s +: 16]));
        check(seg_be[s] == bexp[2*s +: 2], {tag, " R5 byte enables"},
              32'(seg_be[s]), 32'(bexp[2*s +: 2]));
      end
    end
    if (w && seg_n >= 2)
      check(seg_gap[1] == 1'b0, {tag, " R2 no idle clock between cycles"}, 32'(seg_gap[1]), 0);
    if (!we) begin
      rexp = w ? {rd_model(a + 32'd2), rd_model(a)} : {16'h0, rd_model(a)};
      rexp = ref_data(m, w, rexp);
      check(rdat == rexp, {tag, " R6 R7 read data"}, rdat, rexp);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    check(nb_stb === 1'b0, "R1 strobe low after reset", 32'(nb_stb), 0);
    check(rsp_valid === 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
  endtask

  task automatic t_write_modes;
    run_req(32'h0000_1000, 32'hA1B2_C3D4, 4'b0111, 1'b1, 2'b00, 1'b1, 0, 4'd4, 0, "wr32 pass");
    run_req(32'h0000_2004, 32'h1122_3344, 4'b0001, 1'b1, 2'b01, 1'b1, 1, 4'd4, 0, "wr32 half");
    run_req(32'h0010_0008, 32'h5566_7788, 4'b0011, 1'b1, 2'b10, 1'b1, 2, 4'd4, 0, "wr32 word");
    run_req(32'h0000_300C, 32'h99AA_BBCC, 4'b1101, 1'b1, 2'b11, 1'b1, 0, 4'd4, 0, "wr32 mode3");
  endtask

  task automatic t_read_modes;
    run_req(32'h0000_4010, 32'h0, 4'hF, 1'b0, 2'b00, 1'b1, 0, 4'd4, 0, "rd32 pass");
    run_req(32'h0000_4020, 32'h0, 4'hF, 1'b0, 2'b01, 1'b1, 3, 4'd4, 0, "rd32 half");
    run_req(32'h0000_4030, 32'h0, 4'hF, 1'b0, 2'b10, 1'b1, 1, 4'd4, 0, "rd32 word");
  endtask

  task automatic t_min_length;
    run_req(32'h0000_5000, 32'hDEAD_BEEF, 4'hF, 1'b1, 2'b00, 1'b1, 0, 4'd6, 0, "R3 min 6");
    run_req(32'h0000_5040, 32'h0, 4'hF, 1'b0, 2'b00, 1'b1, 0, 4'd2, 0, "R3 floor 4");
    run_req(32'h0000_5080, 32'h0, 4'hF, 1'b0, 2'b01, 1'b0, 0, 4'd0, 0, "R3 floor zero");
  endtask

  task automatic t_slow_ack;
    run_req(32'h0000_6000, 32'h0, 4'hF, 1'b0, 2'b10, 1'b1, 7, 4'd4, 0, "R4 late ack");
    run_req(32'h0000_6100, 32'h0BAD_F00D, 4'hF, 1'b1, 2'b01, 1'b1, 5, 4'd5, 0, "R4 ack after min");
  endtask

  task automatic t_narrow;
    run_req(32'h0000_7002, 32'hFFFF_1234, 4'b1110, 1'b1, 2'b01, 1'b0, 0, 4'd4, 0, "R7 wr16 swap");
    run_req(32'h0000_7006, 32'hEEEE_5678, 4'b0001, 1'b1, 2'b10, 1'b0, 0, 4'd4, 0, "R7 wr16 mode2");
    run_req(32'h0000_700A, 32'h0, 4'hF, 1'b0, 2'b00, 1'b0, 2, 4'd4, 0, "R7 rd16 pass");
    run_req(32'h0000_700E, 32'h0, 4'hF, 1'b0, 2'b10, 1'b0, 0, 4'd4, 0, "R7 rd16 mode2");
  endtask

  task automatic t_busy_hold;
    run_req(32'h0000_8000, 32'hCAFE_0123, 4'hF, 1'b1, 2'b10, 1'b1, 1, 4'd4, 1, "R8 held valid wr");
    run_req(32'h0000_8100, 32'h0, 4'hF, 1'b0, 2'b01, 1'b1, 0, 4'd4, 1, "R8 held valid rd");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    seg_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_modes();
    t_read_modes();
    t_min_length();
    t_slow_ack();
    t_narrow();
    t_busy_hold();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule